// File: doc/BRIEF.md
# Rectangular Frame-Memory Transfer Streamer

This block carries a rectangle of 16-bit pixels between a 32-bit host data port and a frame memory of 1024 by 512 pixels, in either direction. A start command supplies a position word, a size word and a direction bit. The block then walks the rectangle in raster order, two pixels per host word, and drives one memory port per pixel lane. The memory port carries an address, a write enable, write data, a read enable and read data that returns one cycle later.

Host words may arrive back to back or with gaps of any length. The walk cursor, meaning the column within the current row and the row count, is held between words, so a transfer split into many bursts lands exactly like one that arrives in a single burst. A row with an odd width makes a word straddle two rows. The block reports whether a transfer is active, whether an active transfer is a read, and gives a one-cycle pulse when the last pixel has been moved.

Top module: `vram_xfer_streamer`

## Requirements
- R1: The start column is `startPos[9:0]` and the start row is `startPos[24:16]`. All other bits of the position word are ignored. The memory address of pixel (x, y) is y*1024 + x, which is `{y[8:0], x[9:0]}`.
- R2: The width is ((`startSize[15:0]` − 1) mod 1024) + 1 and the height is ((`startSize[31:16]` − 1) mod 512) + 1. A zero width field therefore means 1024 and a zero height field means 512.
- R3: Each host word holds two pixels. Bits 15:0 are the earlier pixel and drive memory lane 0 (`memAddr[18:0]`, `memWdata[15:0]`, `memRdata[15:0]`). Bits 31:16 are the later pixel and use lane 1 (`memAddr[37:19]`, `memWdata[31:16]`, `memRdata[31:16]`). The count is kept in pixels, so with an odd width one word covers the end of one row and the start of the next.
- R4: Pixels are visited left to right, then top to bottom. The column wraps modulo 1024 and the row wraps modulo 512.
- R5: Idle cycles between host words do not disturb the cursor. The next word continues at the pixel after the last one moved.
- R6: On a write, when `maskSet` is high in the cycle the word is accepted, bit 15 of each stored pixel is forced to 1. Otherwise the pixel is stored unchanged.
- R7: `busy` rises the cycle after a start and falls the cycle after the last pixel is moved. `readActive` follows `busy` for read transfers and stays low for write transfers.
- R8: `done` is high for exactly one cycle, the cycle after the word that moves the last pixel. A lane whose pixel lies past the end of the rectangle is not enabled.
- R9: A start while a transfer is active abandons the old one without a `done` pulse and begins the new one from its first pixel. A host word or read request in the same cycle as a start is dropped.
- R10: A host word (`wrValid`) is ignored unless a write transfer is active. A read request (`rdReq`) is ignored unless a read transfer is active. An ignored word drives no memory enable and moves no cursor.
- R11: On an accepted read request, `rdValid` is high in the next cycle and `rdData` holds lane 0 data in bits 15:0 and lane 1 data in bits 31:16. A lane past the end of the rectangle reads as zero.
- R12: After reset, `busy`, `readActive`, `done`, `rdValid` and all memory enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start a new transfer this cycle |
| startPos | input | 32 | Position word: column in 9:0, row in 24:16 |
| startSize | input | 32 | Size word: width in 15:0, height in 31:16 |
| startRead | input | 1 | Direction of the new transfer: 1 = read from memory |
| maskSet | input | 1 | Force bit 15 of written pixels |
| wrValid | input | 1 | Host write word present |
| wrData | input | 32 | Host write word, two pixels |
| rdReq | input | 1 | Host requests the next read word |
| rdValid | output | 1 | Read word present on rdData |
| rdData | output | 32 | Read word, two pixels |
| memAddr | output | 38 | Per-lane pixel address, 19 bits each |
| memWe | output | 2 | Per-lane write enable |
| memWdata | output | 32 | Per-lane write pixel |
| memRe | output | 2 | Per-lane read enable |
| memRdata | input | 32 | Per-lane read pixel, one cycle after memRe |
| busy | output | 1 | Transfer active |
| readActive | output | 1 | Active transfer is a read |
| done | output | 1 | One-cycle pulse when the transfer completes |

## Verification
A start command and a host data word can land in the same cycle, and so can a restart and an unfinished transfer. The bench provokes the first by raising `startValid` and `wrValid` together partway through a write rectangle. At that edge it requires every memory enable to be low, and it requires the next words to land at the first pixels of the new rectangle. It provokes the second by restarting before the old rectangle is exhausted, and it judges the abort by the absence of a `done` pulse and by the new addresses being walked from pixel zero.

// File: rtl/vram_xfer_pkg.sv
package vram_xfer_pkg;

  // Strobes passed from the control FSM to the datapath each cycle.
  // At most one of the three is high in any cycle.
  typedef struct packed {
    logic load;    // capture position/size, clear the cursor
    logic wrStep;  // move one host word into memory
    logic rdStep;  // fetch one host word from memory
  } xferStrobe_t;

endpackage

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl
  import vram_xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        startRead,
  input  logic        wrValid,
  input  logic        rdReq,
  input  logic        finish,
  output xferStrobe_t strobe,
  output logic        busy,
  output logic        readActive,
  output logic        done
);

  logic busyQ;
  logic isReadQ;
  logic doneQ;
  logic step;

  // A start takes priority over any word in the same cycle (R9).
  // A word only counts when the direction matches (R10).
  always_comb begin
    strobe.load   = startValid;
    strobe.wrStep = !startValid && busyQ && !isReadQ && wrValid;
    strobe.rdStep = !startValid && busyQ &&  isReadQ && rdReq;
    step          = strobe.wrStep || strobe.rdStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      isReadQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= step && finish;
      if (startValid) begin
        busyQ   <= 1'b1;
        isReadQ <= startRead;
      end else if (step && finish) begin
        busyQ <= 1'b0;
      end
    end
  end

  assign busy       = busyQ;
  assign readActive = busyQ && isReadQ;
  assign done       = doneQ;

endmodule

// File: rtl/vram_xfer_dp.sv
module vram_xfer_dp
  import vram_xfer_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int PW = 16,
  parameter int DW = 32,
  localparam int LANES = DW / PW,
  localparam int AW    = XW + YW,
  localparam int HALF  = DW / 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  xferStrobe_t         strobe,
  input  logic [DW-1:0]       startPos,
  input  logic [DW-1:0]       startSize,
  input  logic                maskSet,
  input  logic [DW-1:0]       wrData,
  input  logic [LANES*PW-1:0] memRdata,
  output logic [LANES*AW-1:0] memAddr,
  output logic [LANES-1:0]    memWe,
  output logic [LANES-1:0]    memRe,
  output logic [LANES*PW-1:0] memWdata,
  output logic                rdValid,
  output logic [DW-1:0]       rdData,
  output logic                finish
);

  // Rectangle origin and extent, both extents stored minus one so that
  // a zero field naturally encodes the full span.
  logic [XW-1:0] baseX;
  logic [YW-1:0] baseY;
  logic [XW-1:0] widthM1;
  logic [YW-1:0] heightM1;

  // Resume cursor: column inside the row and rows already finished.
  logic [XW-1:0] col;
  logic [YW-1:0] row;

  logic [LANES-1:0] rdLaneQ;
  logic             rdValidQ;
  logic [PW-1:0]    forceBits;
  logic             unusedFields;

  // Only some bits of the command words are decoded.
  assign unusedFields = ^{startPos, startSize};
  assign forceBits    = {maskSet, {(PW-1){1'b0}}};

  // Each lane takes the cursor left by the lane before it.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [XW-1:0] colHere;
    logic [XW-1:0] colNext;
    logic [YW-1:0] rowHere;
    logic [YW-1:0] rowNext;
    logic          onHere;
    logic          endOfRow;
    logic          lastHere;
    logic          finAcc;
    logic [XW-1:0] px;
    logic [YW-1:0] py;

    if (g == 0) begin : gHead
      assign colHere = col;
      assign rowHere = row;
      assign onHere  = 1'b1;
      assign finAcc  = lastHere;
    end else begin : gTail
      assign colHere = gLane[g-1].colNext;
      assign rowHere = gLane[g-1].rowNext;
      assign onHere  = gLane[g-1].onHere && !gLane[g-1].lastHere;
      assign finAcc  = gLane[g-1].finAcc || (onHere && lastHere);
    end

    assign endOfRow = (colHere == widthM1);
    assign lastHere = endOfRow && (rowHere == heightM1);
    assign colNext  = endOfRow ? '0 : colHere + 1'b1;
    assign rowNext  = endOfRow ? rowHere + 1'b1 : rowHere;

    // Column and row both wrap at the memory edges by width overflow.
    assign px = baseX + colHere;
    assign py = baseY + rowHere;

    assign memAddr[g*AW +: AW]  = {py, px};
    assign memWe[g]             = strobe.wrStep && onHere;
    assign memRe[g]             = strobe.rdStep && onHere;
    assign memWdata[g*PW +: PW] = wrData[g*PW +: PW] | forceBits;
    assign rdData[g*PW +: PW]   = rdLaneQ[g] ? memRdata[g*PW +: PW] : '0;
  end

  assign finish  = gLane[LANES-1].finAcc;
  assign rdValid = rdValidQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseX    <= '0;
      baseY    <= '0;
      widthM1  <= '0;
      heightM1 <= '0;
      col      <= '0;
      row      <= '0;
      rdValidQ <= 1'b0;
      rdLaneQ  <= '0;
    end else begin
      rdValidQ <= strobe.rdStep;
      rdLaneQ  <= strobe.rdStep ? memRe : '0;
      if (strobe.load) begin
        baseX    <= startPos[XW-1:0];
        baseY    <= startPos[HALF +: YW];
        widthM1  <= startSize[XW-1:0] - 1'b1;
        heightM1 <= startSize[HALF +: YW] - 1'b1;
        col      <= '0;
        row      <= '0;
      end else if (strobe.wrStep || strobe.rdStep) begin
        col <= gLane[LANES-1].colNext;
        row <= gLane[LANES-1].rowNext;
      end
    end
  end

endmodule

// File: rtl/vram_xfer_streamer.sv
module vram_xfer_streamer
  import vram_xfer_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int PW = 16,
  parameter int DW = 32,
  localparam int LANES = DW / PW,
  localparam int AW    = XW + YW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  input  logic [DW-1:0]       startPos,
  input  logic [DW-1:0]       startSize,
  input  logic                startRead,
  input  logic                maskSet,
  input  logic                wrValid,
  input  logic [DW-1:0]       wrData,
  input  logic                rdReq,
  output logic                rdValid,
  output logic [DW-1:0]       rdData,
  output logic [LANES*AW-1:0] memAddr,
  output logic [LANES-1:0]    memWe,
  output logic [LANES*PW-1:0] memWdata,
  output logic [LANES-1:0]    memRe,
  input  logic [LANES*PW-1:0] memRdata,
  output logic                busy,
  output logic                readActive,
  output logic                done
);

  xferStrobe_t strobe;
  logic        finish;

  vram_xfer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startRead  (startRead),
    .wrValid    (wrValid),
    .rdReq      (rdReq),
    .finish     (finish),
    .strobe     (strobe),
    .busy       (busy),
    .readActive (readActive),
    .done       (done)
  );

  vram_xfer_dp #(
    .XW (XW),
    .YW (YW),
    .PW (PW),
    .DW (DW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startPos  (startPos),
    .startSize (startSize),
    .maskSet   (maskSet),
    .wrData    (wrData),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memRe     (memRe),
    .memWdata  (memWdata),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .finish    (finish)
  );

endmodule

// File: rtl/vram_xfer_checker.sv
module vram_xfer_checker #(
  parameter int LANES = 2,
  parameter int PW    = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                startValid,
  input logic                maskSet,
  input logic [LANES-1:0]    memWe,
  input logic [LANES-1:0]    memRe,
  input logic [LANES*PW-1:0] memWdata,
  input logic                rdValid,
  input logic                busy,
  input logic                readActive,
  input logic                done
);

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (memWe == '0 && memRe == '0));

  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rstN)
    !((|memWe) && (|memRe)));

  a_r9_start_drops_word: assert property (@(posedge clk) disable iff (!rstN)
    startValid |-> (memWe == '0 && memRe == '0));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r7_read_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    readActive |-> busy);

  a_r11_read_returns: assert property (@(posedge clk) disable iff (!rstN)
    (|memRe) |=> rdValid);

  a_r3_lanes_in_order: assert property (@(posedge clk) disable iff (!rstN)
    (((memWe + 1'b1) & memWe) == '0) && (((memRe + 1'b1) & memRe) == '0));

  a_r6_mask_bit: assert property (@(posedge clk) disable iff (!rstN)
    (maskSet && memWe[0]) |-> memWdata[PW-1]);

endmodule

bind vram_xfer_streamer vram_xfer_checker #(
  .LANES (LANES),
  .PW    (PW)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startValid (startValid),
  .maskSet    (maskSet),
  .memWe      (memWe),
  .memRe      (memRe),
  .memWdata   (memWdata),
  .rdValid    (rdValid),
  .busy       (busy),
  .readActive (readActive),
  .done       (done)
);

// File: tb/vram_xfer_streamer_bench.sv
`timescale 1ns/1ps
module vram_xfer_streamer_bench;

  localparam int AW = 19;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] startPos = '0;
  logic [31:0] startSize = '0;
  logic        startRead = 1'b0;
  logic        maskSet = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdReq = 1'b0;
  logic        rdValid;
  logic [31:0] rdData;
  logic [37:0] memAddr;
  logic [1:0]  memWe;
  logic [31:0] memWdata;
  logic [1:0]  memRe;
  logic [31:0] memRdata = '0;
  logic        busy;
  logic        readActive;
  logic        done;

  int checks = 0;
  int fails = 0;

  // reference model state
  int mx0, my0, mw, mh, mpix;
  logic [15:0] shadow [int];
  logic [15:0] mem [int];

  always #2.5 clk = ~clk;

  vram_xfer_streamer u_vram_xfer_streamer (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startPos(startPos),
    .startSize(startSize), .startRead(startRead), .maskSet(maskSet),
    .wrValid(wrValid), .wrData(wrData), .rdReq(rdReq), .rdValid(rdValid),
    .rdData(rdData), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRe(memRe), .memRdata(memRdata), .busy(busy), .readActive(readActive),
    .done(done)
  );

  // synchronous frame memory model, one-cycle read latency
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (memWe[i]) mem[int'(memAddr[i*AW +: AW])] = memWdata[i*16 +: 16];
      if (memRe[i])
        memRdata[i*16 +: 16] <= mem.exists(int'(memAddr[i*AW +: AW])) ?
                                mem[int'(memAddr[i*AW +: AW])] : 16'h0;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int expAddr(input int k);
    return (((my0 + k / mw) % 512) * 1024) + ((mx0 + k % mw) % 1024);
  endfunction

  function automatic logic [15:0] shadowAt(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0;
  endfunction

  // Begins and ends just after a falling edge.
  task automatic startXfer(input int x, input int y, input int wf, input int hf,
                           input bit rd, input bit withWord);
    startValid = 1'b1;
    startPos   = {7'($urandom), 9'(y), 6'($urandom), 10'(x)};   // junk bits R1
    startSize  = {16'(hf), 16'(wf)};
    startRead  = rd;
    wrValid    = withWord;
    rdReq      = withWord;
    wrData     = $urandom;
    #1;
    if (withWord) begin
      check("R9 start+word write enables", memWe, 0);
      check("R9 start+word read enables", memRe, 0);
    end
    @(posedge clk); @(negedge clk);
    startValid = 1'b0; wrValid = 1'b0; rdReq = 1'b0;
    mx0 = x; my0 = y;
    mw = ((wf - 1) & 1023) + 1;
    mh = ((hf - 1) & 511) + 1;
    mpix = 0;
    check("R7 busy after start", busy, 1);
    check("R7 readActive after start", readActive, rd);
  endtask

  task automatic endChecks();
    if (mpix >= mw * mh) begin
      check("R8 done pulse", done, 1);
      check("R7 busy cleared", busy, 0);
      check("R7 readActive cleared", readActive, 0);
      @(negedge clk);
      check("R8 done single cycle", done, 0);
    end else begin
      check("R5 busy held between words", busy, 1);
      check("R8 no early done", done, 0);
    end
  endtask

  task automatic wrWord(input logic [31:0] d, input bit m, input int gap);
    repeat (gap) @(negedge clk);
    wrValid = 1'b1; wrData = d; maskSet = m;
    #1;
    for (int i = 0; i < 2; i++) begin
      int k = mpix + i;
      if (k < mw * mh) begin
        logic [15:0] px = d[i*16 +: 16] | {m, 15'h0};
        check("R3 lane write enable", memWe[i], 1);
        check("R4 lane address", memAddr[i*AW +: AW], expAddr(k));
        check("R6 lane write data", memWdata[i*16 +: 16], px);
        shadow[expAddr(k)] = px;
      end else begin
        check("R8 lane past end not written", memWe[i], 0);
      end
    end
    @(posedge clk); @(negedge clk);
    wrValid = 1'b0; maskSet = 1'b0;
    mpix += 2;
    endChecks();
  endtask

  task automatic rdWord(input int gap);
    logic [31:0] expWord = '0;
    repeat (gap) @(negedge clk);
    rdReq = 1'b1;
    #1;
    for (int i = 0; i < 2; i++) begin
      int k = mpix + i;
      if (k < mw * mh) begin
        check("R11 lane read enable", memRe[i], 1);
        check("R4 read lane address", memAddr[i*AW +: AW], expAddr(k));
        expWord[i*16 +: 16] = shadowAt(expAddr(k));
      end else begin
        check("R11 lane past end not read", memRe[i], 0);
      end
    end
    @(posedge clk); @(negedge clk);
    rdReq = 1'b0;
    check("R11 rdValid", rdValid, 1);
    check("R11 rdData", rdData, expWord);
    mpix += 2;
    endChecks();
  endtask

  task automatic writeRect(input int x, input int y, input int wf, input int hf, input bit m);
    startXfer(x, y, wf, hf, 1'b0, 1'b0);
    while (mpix < mw * mh) wrWord($urandom, m, $urandom_range(0, 3));
  endtask

  task automatic readRect(input int x, input int y, input int wf, input int hf);
    startXfer(x, y, wf, hf, 1'b1, 1'b0);
    while (mpix < mw * mh) rdWord($urandom_range(0, 3));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 busy", busy, 0);
    check("R12 readActive", readActive, 0);
    check("R12 done", done, 0);
    check("R12 rdValid", rdValid, 0);
    check("R12 memWe", memWe, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R10 words while idle are ignored
    wrValid = 1'b1; wrData = 32'hdead_beef; rdReq = 1'b1;
    #1;
    check("R10 idle word write enable", memWe, 0);
    check("R10 idle request read enable", memRe, 0);
    @(posedge clk); @(negedge clk);
    wrValid = 1'b0; rdReq = 1'b0;
    check("R10 idle request no rdValid", rdValid, 0);
    check("R10 idle word no busy", busy, 0);

    // R1 R4 corner: both wraps, odd width so pairs straddle rows (R3)
    startXfer(1021, 510, 5, 3, 1'b0, 1'b0);
    check("R1 first address", memAddr[AW-1:0], 510 * 1024 + 1021);
    while (mpix < mw * mh) wrWord($urandom, 1'b0, $urandom_range(0, 4));

    // read it back; writes during a read are ignored (R10)
    startXfer(1021, 510, 5, 3, 1'b1, 1'b0);
    wrValid = 1'b1; wrData = $urandom;
    #1;
    check("R10 write word during read", memWe, 0);
    @(posedge clk); @(negedge clk);
    wrValid = 1'b0;
    while (mpix < mw * mh) rdWord($urandom_range(0, 4));

    // R6 mask forcing
    writeRect(100, 20, 4, 2, 1'b1);
    readRect(100, 20, 4, 2);

    // R9 abort: restart mid-transfer together with a word
    startXfer(10, 10, 8, 4, 1'b0, 1'b0);
    wrWord($urandom, 1'b0, 0);
    wrWord($urandom, 1'b0, 2);
    startXfer(200, 300, 3, 1, 1'b0, 1'b1);
    check("R9 no done on abort", done, 0);
    check("R9 restart first address", memAddr[AW-1:0], 300 * 1024 + 200);
    while (mpix < mw * mh) wrWord($urandom, 1'b0, 1);
    readRect(200, 300, 3, 1);

    // R2 zero width field means 1024 (with column wrap)
    writeRect(512, 7, 0, 1, 1'b0);
    // R2 zero height field means 512 (with row wrap)
    writeRect(33, 5, 1, 0, 1'b0);
    readRect(33, 5, 1, 0);

    // random rectangles, write then read back
    for (int n = 0; n < 24; n++) begin
      int x = $urandom_range(0, 1023);
      int y = $urandom_range(0, 511);
      int w = $urandom_range(1, 9);
      int h = $urandom_range(1, 5);
      bit m = 1'($urandom);
      writeRect(x, y, w, h, m);
      readRect(x, y, w, h);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule